// File: doc/BRIEF.md
# Partial-Fill Direct-Mapped Instruction Cache

This block sits between a 32-bit instruction fetch port and a word-wide instruction memory. It is direct-mapped, with 256 lines of four 32-bit words. A fetch either hits and returns the stored word one cycle after it is accepted, or it misses and starts a refill.

A refill does not load the whole line. It reads memory from the requested word up to the last word of the line. The line's tag is then set to the full word address that missed, so the tag also records where the fill began. A later fetch of a word at or after that point hits. A fetch of an earlier word in the same line misses and refills again from its own offset. The requested word is returned as soon as memory delivers it. The fetch port stays not-ready until the rest of the line has been written.

A global invalidate input clears every line in one cycle. It is used when the core isolates its cache, and reset has the same effect. A bypass input sends a fetch straight to memory as a single read and leaves the tags and data untouched. It is used when cache emulation is turned off. The memory side is a request/valid interface with any latency.

Top module: `icache_partial`

## Requirements
- R1: After reset the fetch port is ready, no response is pending and no memory request is issued.
- R2: On a miss, memory is read one word at a time in rising order, from the requested word address (fetch address bits [31:2], with bits [1:0] taken as zero) up to word 3 of the line. Word offset is address bits [3:2]. No word below the requested one is read.
- R3: The response to a miss or to a bypass fetch carries the word that memory returned for the requested address.
- R4: A fetch hits only when the line tag matches on address bits [31:4] and the word offset is no lower than the offset where the fill started. A hit issues no memory read and returns the word stored earlier, even if memory has changed since.
- R5: A fetch of a word below the fill start of a valid line misses and refills from that word. At offset 0 this reads all four words.
- R6: Lines are indexed by address bits [11:4]. A fetch with the same index but a different tag misses and replaces the line.
- R7: The invalidate input, asserted for one cycle, makes every later fetch miss until that line is refilled.
- R8: A bypass fetch makes exactly one memory read and returns its data. It neither fills a line nor changes any tag.
- R9: While a refill is running, the fetch port is not ready, even after the requested word has been returned. The port becomes ready in the cycle after the line's word 3 arrives.
- R10: A hit raises the response valid exactly one cycle after the fetch is accepted.
- R11: After reset or invalidate, every tag is all ones. No address hits such a tag, including 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all lines |
| flush_i | input | 1 | Invalidate every line at the next edge |
| bypass_i | input | 1 | Send the fetch straight to memory, untouched by the cache |
| req_valid_i | input | 1 | Fetch request |
| req_addr_i | input | 32 | Fetch byte address |
| req_ready_o | output | 1 | Fetch port can accept a request |
| resp_valid_o | output | 1 | One-cycle pulse with the fetched word |
| resp_data_o | output | 32 | Fetched instruction word |
| mem_req_o | output | 1 | Memory read request, held until answered |
| mem_addr_o | output | 32 | Word-aligned memory read address |
| mem_valid_i | input | 1 | Memory data valid for the current request |
| mem_data_i | input | 32 | Memory read data |

## Verification
The checks inside the design assume that memory raises its valid only while a request is outstanding, and answers each request with a single one-cycle valid. They also assume that the fetch address is not changed in the cycle it is accepted. The bench memory model answers only an asserted request, after a latency the bench varies. It drops valid in the cycle after each word and restarts its count on the next address. The fetch task holds the request for exactly one accepting edge. The invalidate input is pulsed only while no fetch is being accepted.

// File: rtl/icache_partial.sv
module icache_partial #(
  parameter int INDEX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_i,
  input  logic        bypass_i,
  input  logic        req_valid_i,
  input  logic [31:0] req_addr_i,
  output logic        req_ready_o,
  output logic        resp_valid_o,
  output logic [31:0] resp_data_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_valid_i,
  input  logic [31:0] mem_data_i
);
  localparam int LINES  = 1 << INDEX_W;
  localparam int WORDS  = LINES * 4;
  localparam int IDX_HI = INDEX_W + 3;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_BYP} st_t;

  st_t         st;
  logic [31:0] tag_q  [LINES];
  logic [31:0] data_q [WORDS];
  logic [31:0] cur_addr;
  logic        first_q;

  wire [INDEX_W-1:0] idx       = req_addr_i[IDX_HI:4];
  wire [1:0]         off       = req_addr_i[3:2];
  wire [31:0]        word_addr = {req_addr_i[31:2], 2'b00};
  wire [31:0]        cur_tag   = tag_q[idx];
  wire               hit       = (cur_tag[31:4] == word_addr[31:4]) && (word_addr >= cur_tag);
  wire               accept    = req_valid_i && req_ready_o;
  wire               miss_acc  = accept && !bypass_i && !hit;

  assign req_ready_o = (st == S_IDLE);
  assign mem_req_o   = (st != S_IDLE);
  assign mem_addr_o  = cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '1;
    end else if (flush_i) begin
      for (int i = 0; i < LINES; i++) tag_q[i] <= '1;
    end else if (miss_acc) begin
      tag_q[idx] <= word_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_valid_i)
      data_q[{cur_addr[IDX_HI:4], cur_addr[3:2]}] <= mem_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cur_addr     <= '0;
      first_q      <= 1'b0;
      resp_valid_o <= 1'b0;
      resp_data_o  <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (bypass_i) begin
            st       <= S_BYP;
            cur_addr <= word_addr;
          end else if (hit) begin
            resp_valid_o <= 1'b1;
            resp_data_o  <= data_q[{idx, off}];
          end else begin
            st       <= S_FILL;
            cur_addr <= word_addr;
            first_q  <= 1'b1;
          end
        end
        S_BYP: if (mem_valid_i) begin
          resp_valid_o <= 1'b1;
          resp_data_o  <= mem_data_i;
          st           <= S_IDLE;
        end
        S_FILL: if (mem_valid_i) begin
          if (first_q) begin
            resp_valid_o <= 1'b1;
            resp_data_o  <= mem_data_i;
            first_q      <= 1'b0;
          end
          if (cur_addr[3:2] == 2'd3) st <= S_IDLE;
          else cur_addr <= cur_addr + 32'd4;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && mem_valid_i && mem_addr_o[3:2] != 2'd3) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 32'd4));

  p_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bypass_i && hit) |=> (!mem_req_o && req_ready_o));

  p_miss_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bypass_i && !hit) |=> (mem_req_o && mem_addr_o == $past(word_addr)));

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !hit);

  p_byp_tag_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bypass_i && !flush_i) |=> (tag_q[$past(idx)] == $past(cur_tag)));

  p_fill_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL && mem_valid_i && mem_addr_o[3:2] == 2'd3) |=> req_ready_o);

  p_hit_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !bypass_i && hit) |=> resp_valid_o);
endmodule

// File: tb/test_icache_partial.sv
`timescale 1ns/1ps
module test_icache_partial;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        bypass_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_ready_o, resp_valid_o, mem_req_o;
  logic [31:0] resp_data_o, mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_data_i = '0;

  always #4 clk = ~clk;

  icache_partial i_icache_partial (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .bypass_i(bypass_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
    .resp_valid_o(resp_valid_o), .resp_data_o(resp_data_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i));

  int          checks = 0;
  int          fails  = 0;
  int          lat    = 0;
  int          rd_cnt = 0;
  logic [31:0] salt   = '0;
  logic [31:0] rd_log [16];

  function automatic logic [31:0] mem_word(logic [31:0] a, logic [31:0] s);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000 ^ s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers an outstanding request after lat cycles
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_valid_i) begin
        mem_valid_i = 1'b0;
        cnt = 0;
      end else if (mem_req_o) begin
        if (cnt >= lat) begin
          mem_valid_i = 1'b1;
          mem_data_i  = mem_word(mem_addr_o, salt);
          rd_log[rd_cnt % 16] = mem_addr_o;
          rd_cnt++;
        end else cnt++;
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input logic byp, output logic [31:0] data,
                       output int nrd, output logic [31:0] first_rd, output int cyc,
                       output logic rdy_at_resp, output logic got);
    int mark;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    mark = rd_cnt;
    req_valid_i = 1'b1; req_addr_i = a; bypass_i = byp;
    @(negedge clk);
    req_valid_i = 1'b0; bypass_i = 1'b0;
    cyc = 1; got = 1'b0; data = '0; rdy_at_resp = 1'b0;
    while (!got && cyc < 200) begin
      if (resp_valid_o) begin
        got = 1'b1; data = resp_data_o; rdy_at_resp = req_ready_o;
      end else begin
        @(negedge clk); cyc++;
      end
    end
    for (int k = 0; k < 200 && !req_ready_o; k++) @(negedge clk);
    nrd = rd_cnt - mark;
    first_rd = rd_log[mark % 16];
  endtask

  // {address, bypass, expected memory reads}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {32'h0000_1008, 1'b0, 3'd2},  // R2 fill from offset 2
    {32'h0000_100C, 1'b0, 3'd0},  // R4 later word hits
    {32'h0000_1000, 1'b0, 3'd4},  // R5 earlier word misses
    {32'h0000_1004, 1'b0, 3'd0},  // R4
    {32'h0000_2004, 1'b0, 3'd3},  // R6 conflict
    {32'h0000_1000, 1'b0, 3'd4},  // R6 evicted
    {32'h0000_30F0, 1'b0, 3'd4},
    {32'h0000_30FC, 1'b0, 3'd0},
    {32'h0000_5550, 1'b1, 3'd1},  // R8 bypass
    {32'h0000_5550, 1'b0, 3'd4},  // R8 bypass did not fill
    {32'h0000_30F4, 1'b1, 3'd1},  // R8 bypass of cached word
    {32'h0000_30F8, 1'b0, 3'd0}
  };

  initial begin
    logic [31:0] d, fr, a;
    int nrd, cyc, exp_n;
    logic rdy, got, byp;
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1, "R1 ready", {31'd0, req_ready_o}, 32'd1);
    chk(resp_valid_o == 1'b0, "R1 resp", {31'd0, resp_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req_o == 1'b0, "R1 mem_req", {31'd0, mem_req_o}, 32'd0);

    fetch(32'hFFFF_FFFC, 1'b0, d, nrd, fr, cyc, rdy, got);
    chk(nrd == 1, "R11 all-ones miss reads", nrd, 1);
    chk(got && d == mem_word(32'hFFFF_FFFC, salt), "R11 data", d, mem_word(32'hFFFF_FFFC, salt));

    for (int i = 0; i < NV; i++) begin
      a = VEC[i][35:4]; byp = VEC[i][3]; exp_n = int'(VEC[i][2:0]);
      lat = i % 3;
      fetch(a, byp, d, nrd, fr, cyc, rdy, got);
      chk(got && d == mem_word(a, salt), "R3 data", d, mem_word(a, salt));
      chk(nrd == exp_n, "R2 R4 R5 R6 R8 read count", nrd, exp_n);
      if (exp_n > 0)
        chk(fr == {a[31:2], 2'b00}, "R2 first read address", fr, {a[31:2], 2'b00});
      if (exp_n == 0)
        chk(cyc == 1, "R10 hit latency", cyc, 1);
      if (exp_n > 1)
        chk(rdy == 1'b0, "R9 ready low during refill", {31'd0, rdy}, 32'd0);
    end

    salt = 32'h0000_0F0F;
    lat = 2;
    fetch(32'h0000_100C, 1'b0, d, nrd, fr, cyc, rdy, got);
    chk(nrd == 0, "R4 stale hit reads", nrd, 0);
    chk(d == mem_word(32'h0000_100C, 32'd0), "R4 stale hit data", d, mem_word(32'h0000_100C, 32'd0));

    @(negedge clk); flush_i = 1'b1;
    @(negedge clk); flush_i = 1'b0;
    fetch(32'h0000_100C, 1'b0, d, nrd, fr, cyc, rdy, got);
    chk(nrd == 1, "R7 miss after invalidate", nrd, 1);
    chk(d == mem_word(32'h0000_100C, salt), "R7 data", d, mem_word(32'h0000_100C, salt));
    fetch(32'h0000_30FC, 1'b0, d, nrd, fr, cyc, rdy, got);
    chk(nrd == 1, "R7 other line cleared", nrd, 1);

    lat = 1;
    fetch(32'h0000_4008, 1'b0, d, nrd, fr, cyc, rdy, got);
    chk(nrd == 2, "R2 offset 2 fill", nrd, 2);
    fetch(32'h0000_4000, 1'b0, d, nrd, fr, cyc, rdy, got);
    chk(nrd == 4 && fr == 32'h0000_4000, "R5 refill from offset 0", fr, 32'h0000_4000);
    fetch(32'h0000_4000, 1'b0, d, nrd, fr, cyc, rdy, got);
    chk(nrd == 0 && d == mem_word(32'h0000_4000, salt), "R5 full line hits", d, mem_word(32'h0000_4000, salt));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule